// File: doc/BRIEF.md
# Sixteen-Line External Interrupt Controller with Grouped Outputs

This block watches sixteen external interrupt pins, brings each one into the local clock domain and decides, per line, whether an interrupt event has happened. Line pairs share a programmable trigger rule: level low, level high, falling edge, rising edge or either edge. Every event is latched into a per-line pending flag. Software later clears the flag by writing a one to its bit.

A per-line mask decides which pending flags reach the outputs. The sixteen lines are folded into three interrupt requests of unequal width for a parent controller. The first request covers four lines, the second covers eight and the third covers four. Software reaches the configuration word, the mask word and the pending word through a plain single-cycle register bus.

Top module: `xirq_grouped_ctrl`

## Requirements
- R1: The 3-bit trigger code selects detection as follows: 000 = pin low, 001 = pin high, 010 = falling edge, 100 = rising edge, 110 and 111 = either edge. Codes 011 and 101 detect nothing.
- R2: Mask bit n set to 1 keeps line n out of its group request. Bit n set to 0 lets it through. A masked line still latches pending events, and clearing its mask bit raises the group request in the cycle after the mask write.
- R3: Writing the pending word clears exactly the pending bits whose written bit is 1. Written 0 bits leave their flags unchanged.
- R4: The configuration word holds eight 3-bit fields at bit offsets 0, 4, 8 … 28. The field at offset 4k governs lines 2k and 2k+1. Bit 3 of every nibble always reads 0.
- R5: irq_grp[0] is the OR of the unmasked pending bits of lines 0–3, irq_grp[1] covers lines 4–11 and irq_grp[2] covers lines 12–15.
- R6: In a level mode, the pending bit is set again on every clock while the level holds. When a clear and a set hit the same bit in one cycle, the bit stays set.
- R7: While reset is asserted, the configuration word reads 0, the mask word reads 0000FFFF, the pending word reads 0 and all three requests are low.
- R8: Bus address 0 selects the configuration word, 1 the mask word (bits 15:0) and 2 the pending word (bits 15:0). Address 3 and all unused bits read 0.
- R9: A pin change applied between clock edges appears in the pending word after the third following rising clock edge, and not after the second.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| ext_pin | input | 16 | Asynchronous external interrupt pins, bit n is line n |
| bus_addr | input | 2 | Register word select |
| bus_wr | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the selected word, combinational |
| irq_grp | output | 3 | Grouped interrupt requests toward the parent controller |

## Verification
The trigger rules are driven with whole-word pin patterns chosen so that each rule reacts to a different subset of bits. Rising and falling transitions are applied under the opposite edge mode to show they are ignored. Alternating patterns show that either-edge mode catches both directions, and transitions under the two dead codes show those codes stay silent. Each pattern's expected pending word also sets a distinct mix of the three group requests, which separates the 4/8/4 line split. Directed cases then cover several rules in turn: one shared field driving only its own line pair, a clear arriving while a level is still held, selective write-one clearing, unmasking of an already latched event, and the exact three-edge latency.

// File: rtl/xirq_pkg.sv
package xirq_pkg;

  localparam int unsigned NUM_LINES   = 16;
  localparam int unsigned NUM_PAIRS   = NUM_LINES / 2;
  localparam int unsigned FIELD_W     = 3;
  localparam int unsigned FIELD_PITCH = 4;
  localparam int unsigned NUM_GROUPS  = 3;

  localparam int unsigned REG_CFG  = 0;
  localparam int unsigned REG_MASK = 1;
  localparam int unsigned REG_PEND = 2;

  typedef enum logic [FIELD_W-1:0] {
    TRIG_LOW   = 3'b000,
    TRIG_HIGH  = 3'b001,
    TRIG_FALL  = 3'b010,
    TRIG_RISE  = 3'b100,
    TRIG_ANY_A = 3'b110,
    TRIG_ANY_B = 3'b111
  } trig_mode_e;

  function automatic int unsigned grp_lo(input int unsigned g);
    case (g)
      0:       return 0;
      1:       return 4;
      default: return 12;
    endcase
  endfunction

  function automatic int unsigned grp_hi(input int unsigned g);
    case (g)
      0:       return 3;
      1:       return 11;
      default: return 15;
    endcase
  endfunction

endpackage

// File: rtl/xirq_line_detect.sv
module xirq_line_detect
  import xirq_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               pin,
  input  logic [FIELD_W-1:0] mode,
  output logic               evt
);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;
  logic                   lvl;
  logic                   rise;
  logic                   fall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], pin};
      prev_q <= sync_q[SYNC_STAGES-1];
    end
  end

  always_comb begin
    lvl  = sync_q[SYNC_STAGES-1];
    rise = lvl & ~prev_q;
    fall = ~lvl & prev_q;
    case (mode)
      TRIG_LOW:               evt = ~lvl;
      TRIG_HIGH:              evt = lvl;
      TRIG_FALL:              evt = fall;
      TRIG_RISE:              evt = rise;
      TRIG_ANY_A, TRIG_ANY_B: evt = rise | fall;
      default:                evt = 1'b0;
    endcase
  end

endmodule

// File: rtl/xirq_group_or.sv
module xirq_group_or #(
  parameter int unsigned NL = 16,
  parameter int unsigned LO = 0,
  parameter int unsigned HI = 3
) (
  input  logic [NL-1:0] pend,
  input  logic [NL-1:0] mask,
  output logic          irq
);

  logic [HI-LO:0] live;

  always_comb begin
    live = pend[HI:LO] & ~mask[HI:LO];
    irq  = |live;
  end

endmodule

// File: rtl/xirq_grouped_ctrl.sv
module xirq_grouped_ctrl
  import xirq_pkg::*;
#(
  parameter int unsigned ADDR_W      = 2,
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_LINES-1:0]  ext_pin,
  input  logic [ADDR_W-1:0]     bus_addr,
  input  logic                  bus_wr,
  input  logic [DATA_W-1:0]     bus_wdata,
  output logic [DATA_W-1:0]     bus_rdata,
  output logic [NUM_GROUPS-1:0] irq_grp
);

  localparam int unsigned CFG_BITS = NUM_PAIRS * FIELD_PITCH;

  logic [1:0] rst_pipe_q;
  logic       rst_sync_n;

  logic [NUM_PAIRS-1:0][FIELD_W-1:0] cfg_q, cfg_d;
  logic [NUM_LINES-1:0] mask_q, mask_d;
  logic [NUM_LINES-1:0] pend_q, pend_d;
  logic [NUM_LINES-1:0] evt_vec;
  logic [NUM_LINES-1:0] clr_vec;
  logic                 wr_cfg, wr_mask, wr_pend;
  logic                 unused_ok;

  // reset: asserted at once, released after two clock edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[1];

  // per-line synchronizer and trigger decode
  for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
    xirq_line_detect #(.SYNC_STAGES(SYNC_STAGES)) u_det (
      .clk  (clk),
      .rst_n(rst_sync_n),
      .pin  (ext_pin[i]),
      .mode (cfg_q[i/2]),
      .evt  (evt_vec[i])
    );
  end

  // next state
  always_comb begin
    wr_cfg  = bus_wr && (bus_addr == ADDR_W'(REG_CFG));
    wr_mask = bus_wr && (bus_addr == ADDR_W'(REG_MASK));
    wr_pend = bus_wr && (bus_addr == ADDR_W'(REG_PEND));
    cfg_d   = cfg_q;
    for (int p = 0; p < NUM_PAIRS; p++) begin
      cfg_d[p] = bus_wdata[p*FIELD_PITCH +: FIELD_W];
    end
    mask_d  = bus_wdata[NUM_LINES-1:0];
    clr_vec = wr_pend ? bus_wdata[NUM_LINES-1:0] : '0;
    pend_d  = (pend_q & ~clr_vec) | evt_vec;   // a new event beats a clear
  end

  // registers
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      cfg_q  <= '0;
      mask_q <= '1;
      pend_q <= '0;
    end else begin
      if (wr_cfg)  cfg_q  <= cfg_d;
      if (wr_mask) mask_q <= mask_d;
      pend_q <= pend_d;
    end
  end

  // read mux
  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      ADDR_W'(REG_CFG): begin
        for (int p = 0; p < NUM_PAIRS; p++) begin
          bus_rdata[p*FIELD_PITCH +: FIELD_W] = cfg_q[p];
        end
      end
      ADDR_W'(REG_MASK): bus_rdata[NUM_LINES-1:0] = mask_q;
      ADDR_W'(REG_PEND): bus_rdata[NUM_LINES-1:0] = pend_q;
      default:           bus_rdata = '0;
    endcase
  end

  // grouped requests
  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
    xirq_group_or #(.NL(NUM_LINES), .LO(grp_lo(g)), .HI(grp_hi(g))) u_or (
      .pend(pend_q),
      .mask(mask_q),
      .irq (irq_grp[g])
    );
  end

  // nibble top bits and upper data bits carry no state
  assign unused_ok = ^{bus_wdata[DATA_W-1:CFG_BITS], bus_wdata[3], bus_wdata[7],
                       bus_wdata[11], bus_wdata[15], bus_wdata[19], bus_wdata[23],
                       bus_wdata[27], bus_wdata[31]};

endmodule

// File: rtl/xirq_grouped_ctrl_chk.sv
module xirq_grouped_ctrl_chk #(
  parameter int unsigned NL     = 16,
  parameter int unsigned NG     = 3,
  parameter int unsigned ADDR_W = 2,
  parameter int unsigned DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [DATA_W-1:0] bus_rdata,
  input logic [NL-1:0]     pend_q,
  input logic [NL-1:0]     mask_q,
  input logic [NL-1:0]     evt_vec,
  input logic [NG-1:0]     irq_grp
);

  // R1: a pending bit only rises where the detector reported an event
  p_rise_needs_event_r1: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend_q & ~$past(pend_q) & ~$past(evt_vec)) == '0));

  // R6: every detected event is latched, even against a clear
  p_set_beats_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_vec != '0) |=> ((pend_q & $past(evt_vec)) == $past(evt_vec)));

  // R3: written ones clear their bits unless a new event arrived
  p_w1c_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == ADDR_W'(2)) |=>
      ((pend_q & $past(bus_wdata[NL-1:0]) & ~$past(evt_vec)) == '0));

  // R3: a write elsewhere never drops a pending bit
  p_pend_kept_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && bus_addr == ADDR_W'(2)) |=> ((pend_q & $past(pend_q)) == $past(pend_q)));

  // R2: with every line masked no request is raised
  p_all_masked_silent_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == '1) |-> (irq_grp == '0));

  // R4: the spare bit of each configuration nibble reads 0
  p_cfg_spare_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == ADDR_W'(0)) |-> ((bus_rdata & 32'h8888_8888) == '0));

endmodule

bind xirq_grouped_ctrl xirq_grouped_ctrl_chk #(
  .NL(xirq_pkg::NUM_LINES), .NG(xirq_pkg::NUM_GROUPS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_sync_n),
  .bus_addr (bus_addr),
  .bus_wr   (bus_wr),
  .bus_wdata(bus_wdata),
  .bus_rdata(bus_rdata),
  .pend_q   (pend_q),
  .mask_q   (mask_q),
  .evt_vec  (evt_vec),
  .irq_grp  (irq_grp)
);

// File: tb/sim_xirq_grouped_ctrl.sv
`timescale 1ns/1ps
module sim_xirq_grouped_ctrl;

  logic        clk;
  logic        rst_n;
  logic [15:0] ext_pin;
  logic [1:0]  bus_addr;
  logic        bus_wr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic [2:0]  irq_grp;

  int n_chk;
  int n_bad;
  bit done;

  xirq_grouped_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .ext_pin(ext_pin),
    .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq_grp(irq_grp)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // {mode[50:48], pins before[47:32], pins after[31:16], expected pending[15:0]}
  localparam int NV = 11;
  localparam logic [50:0] VEC [NV] = '{
    {3'b100, 16'h0000, 16'h00F0, 16'h00F0},  // rising edges caught
    {3'b100, 16'hFFFF, 16'h0F0F, 16'h0000},  // falls ignored in rising mode
    {3'b010, 16'hFFFF, 16'h0F0F, 16'hF0F0},  // falling edges caught
    {3'b010, 16'h0000, 16'h1234, 16'h0000},  // rises ignored in falling mode
    {3'b110, 16'h00FF, 16'h0F0F, 16'h0FF0},  // either edge, code 110
    {3'b111, 16'hAAAA, 16'h5555, 16'hFFFF},  // either edge, code 111
    {3'b001, 16'h0000, 16'h8001, 16'h8001},  // high level
    {3'b000, 16'hFFFF, 16'hFFF0, 16'h000F},  // low level
    {3'b011, 16'h0000, 16'hFFFF, 16'h0000},  // dead code 011
    {3'b101, 16'hFFFF, 16'h0000, 16'h0000},  // dead code 101
    {3'b001, 16'h0000, 16'h0000, 16'h0000}   // high level, pins idle
  };

  function automatic logic [2:0] grp_of(input logic [15:0] p);
    return {|p[15:12], |p[11:4], |p[3:0]};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [31:0] d);
    bus_addr  = a;
    bus_wdata = d;
    bus_wr    = 1'b1;
    @(negedge clk);
    bus_wr    = 1'b0;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  logic [31:0] rd;

  initial begin
    n_chk = 0; n_bad = 0; done = 1'b0;
    rst_n = 1'b0; ext_pin = '0; bus_addr = '0; bus_wr = 1'b0; bus_wdata = '0;
    wait_cyc(3);

    // R7: reset state, sampled while reset is held
    bus_read(2'd0, rd); check("R7 cfg", rd, 32'h0);
    bus_read(2'd1, rd); check("R7 mask", rd, 32'h0000_FFFF);
    bus_read(2'd2, rd); check("R7 pend", rd, 32'h0);
    check("R7 irq", {29'd0, irq_grp}, 32'd0);

    rst_n = 1'b1;
    wait_cyc(5);

    // vector table, all lines unmasked
    bus_write(2'd1, 32'h0);
    for (int v = 0; v < NV; v++) begin
      bus_write(2'd0, {8{1'b0, VEC[v][50:48]}});
      ext_pin = VEC[v][47:32];
      wait_cyc(4);
      bus_write(2'd2, 32'h0000_FFFF);
      wait_cyc(1);
      ext_pin = VEC[v][31:16];
      wait_cyc(4);
      bus_read(2'd2, rd);
      check($sformatf("R1 vector %0d pending", v), rd, {16'h0, VEC[v][15:0]});
      check($sformatf("R5 vector %0d groups", v), {29'd0, irq_grp}, {29'd0, grp_of(VEC[v][15:0])});
    end

    // R4: configuration readback and field sharing
    bus_write(2'd0, 32'hFFFF_FFFF);
    bus_read(2'd0, rd); check("R4 cfg spare bits", rd, 32'h7777_7777);
    ext_pin = '0;
    bus_write(2'd0, 32'h3333_3334);  // only the field at offset 0 is rising
    wait_cyc(4);
    bus_write(2'd2, 32'h0000_FFFF);
    ext_pin = 16'h000F;
    wait_cyc(4);
    bus_read(2'd2, rd); check("R4 field shared by lines 0 and 1", rd, 32'h0000_0003);

    // R8: mask readback, unused address
    bus_write(2'd1, 32'hFFFF_1234);
    bus_read(2'd1, rd); check("R8 mask readback", rd, 32'h0000_1234);
    bus_read(2'd3, rd); check("R8 address 3", rd, 32'h0);

    // R2: masked line latches, unmask raises its group
    bus_write(2'd0, 32'h4444_4444);
    bus_write(2'd1, 32'h0000_FFFF);
    ext_pin = '0;
    wait_cyc(4);
    bus_write(2'd2, 32'h0000_FFFF);
    ext_pin = 16'h0020;
    wait_cyc(4);
    bus_read(2'd2, rd); check("R2 masked line still pending", rd, 32'h0000_0020);
    check("R2 masked group quiet", {29'd0, irq_grp}, 32'd0);
    bus_write(2'd1, 32'h0000_FFDF);
    check("R2 unmask raises group 1", {29'd0, irq_grp}, 32'd2);

    // R3: selective write-one clear
    ext_pin = 16'hFFFF;
    wait_cyc(4);
    bus_write(2'd2, 32'h0000_0000);
    bus_read(2'd2, rd); check("R3 zero write keeps all", rd, 32'h0000_FFFF);
    bus_write(2'd2, 32'h0000_0101);
    bus_read(2'd2, rd); check("R3 clears only written ones", rd, 32'h0000_FEFE);

    // R6: level still held, clear loses
    bus_write(2'd0, 32'h1111_1111);
    wait_cyc(1);
    bus_write(2'd2, 32'h0000_FFFF);
    bus_read(2'd2, rd); check("R6 held level survives clear", rd, 32'h0000_FFFF);
    ext_pin = '0;
    wait_cyc(4);
    bus_write(2'd2, 32'h0000_FFFF);
    bus_read(2'd2, rd); check("R6 clear after release", rd, 32'h0);

    // R9: three-edge latency
    bus_write(2'd0, 32'h4444_4444);
    bus_write(2'd1, 32'h0000_0000);
    wait_cyc(3);
    bus_write(2'd2, 32'h0000_FFFF);
    ext_pin = 16'h0001;
    wait_cyc(2);
    bus_read(2'd2, rd); check("R9 not yet after two edges", rd, 32'h0);
    wait_cyc(1);
    bus_read(2'd2, rd); check("R9 set after three edges", rd, 32'h0000_0001);
    check("R9 group 0 raised", {29'd0, irq_grp}, 32'd1);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #500000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

endmodule